// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a 4-bit logical address into a 5-bit physical address using a small page table held in registers. The upper two bits of the logical address select one of four pages; the lower two bits are the byte position inside a 4-byte page. Each table entry stores a 3-bit frame number and a valid flag. The result is the selected frame number with the byte position appended, so it equals frame × 4 + offset within an 8-frame physical space.

Software fills the table through a write port that updates one entry per cycle. A translation request is a single-cycle strobe carrying the logical address. One cycle later a response strobe appears with either the translated address or a protection fault. A fault is raised when the selected entry is not marked valid, and the address output is then forced to zero.

Top module: `page_translator`

## Requirements
- R1: After reset, rspValid, rspFault and rspAddr are all 0, and every table entry is invalid, so any request made before a write faults.
- R2: rspValid is 1 in exactly the cycle after a cycle with reqValid = 1, and 0 in every other cycle.
- R3: The page number is reqAddr[3:2] and the offset is reqAddr[1:0]. For a valid entry, rspAddr = frame × 4 + offset, with the frame in rspAddr[4:2] and the offset unchanged in rspAddr[1:0].
- R4: A request that selects an entry whose valid flag is 0 returns rspFault = 1 and rspAddr = 0.
- R5: A request that selects an entry whose valid flag is 1 returns rspFault = 0.
- R6: When wrEn = 1, the entry at wrIndex takes wrFrame and wrValid at the next clock edge. Writing wrValid = 0 makes later lookups of that page fault.
- R7: A request and a write that name the same page in the same cycle are answered from the entry as it stood before the write. The next request sees the new entry.
- R8: In a cycle that follows a cycle without a request, rspAddr and rspFault keep their previous values.
- R9: With page 0 in frame 5, page 1 in frame 6 and page 3 in frame 2, logical addresses 0, 3, 4 and 13 translate to 20, 23, 24 and 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrIndex | input | 2 | Page whose entry is written |
| wrFrame | input | 3 | Frame number to store |
| wrValid | input | 1 | Valid flag to store |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 4 | Logical address: page in [3:2], offset in [1:0] |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspAddr | output | 5 | Physical address, zero on a fault |
| rspFault | output | 1 | Protection fault for an invalid entry |

## Verification
The bench first aims at the lookup made before any write: a design that did not clear the valid flags at reset would return a stale frame instead of faulting. Then it checks a page that was invalidated after being valid. A design that only looked at the stored frame would keep translating it, and one that skipped the zeroing would leak the old frame bits on rspAddr. A write and a lookup of the same page in the same cycle catch a design that forwards the new entry. Quiet cycles catch outputs that drift when there is no request. Random back-to-back requests mixed with writes compare every response against a reference table kept in the bench, which exposes a swapped field split or a wrong one-cycle latency.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic writeEntry;   // update one table entry this cycle
    logic loadResult;   // capture a translation result this cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/pt_translate_ctrl.sv
module pt_translate_ctrl
  import pt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         reqValid,
  output ctrlStrobes_t strobes,
  output logic         rspValid
);
  always_comb begin
    strobes.writeEntry = wrEn;
    strobes.loadResult = reqValid;
  end

  // Response strobe trails the request by exactly one cycle.
  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/pt_translate_datapath.sv
module pt_translate_datapath
  import pt_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int OFFSET_BITS = 2,
  parameter int FRAME_BITS  = 3,
  localparam int NUM_PAGES  = 1 << PAGE_BITS,
  localparam int LOG_W      = PAGE_BITS + OFFSET_BITS,
  localparam int PHYS_W     = FRAME_BITS + OFFSET_BITS
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [PAGE_BITS-1:0]  wrIndex,
  input  logic [FRAME_BITS-1:0] wrFrame,
  input  logic                  wrValid,
  input  logic [LOG_W-1:0]      reqAddr,
  output logic [PHYS_W-1:0]     rspAddr,
  output logic                  rspFault
);
  logic [FRAME_BITS-1:0]  frameTab [NUM_PAGES];
  logic [NUM_PAGES-1:0]   validTab;
  logic [PAGE_BITS-1:0]   pageSel;
  logic [OFFSET_BITS-1:0] offsetSel;
  logic [FRAME_BITS-1:0]  hitFrame;
  logic                   hitValid;

  // One register slot per page; all slots start invalid.
  for (genvar i = 0; i < NUM_PAGES; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        frameTab[i] <= '0;
        validTab[i] <= 1'b0;
      end else if (strobes.writeEntry && (wrIndex == PAGE_BITS'(i))) begin
        frameTab[i] <= wrFrame;
        validTab[i] <= wrValid;
      end
    end
  end

  // Field split and table lookup (reads the pre-write contents).
  always_comb begin
    pageSel   = reqAddr[LOG_W-1:OFFSET_BITS];
    offsetSel = reqAddr[OFFSET_BITS-1:0];
    hitFrame  = frameTab[pageSel];
    hitValid  = validTab[pageSel];
  end

  // Registered result: frame concatenated with offset, or zero on a fault.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAddr  <= '0;
      rspFault <= 1'b0;
    end else if (strobes.loadResult) begin
      rspFault <= ~hitValid;
      rspAddr  <= hitValid ? {hitFrame, offsetSel} : '0;
    end
  end
endmodule

// File: rtl/page_translator.sv
module page_translator
  import pt_pkg::*;
#(
  parameter int PAGE_BITS   = 2,
  parameter int OFFSET_BITS = 2,
  parameter int FRAME_BITS  = 3,
  localparam int LOG_W      = PAGE_BITS + OFFSET_BITS,
  localparam int PHYS_W     = FRAME_BITS + OFFSET_BITS
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [PAGE_BITS-1:0]  wrIndex,
  input  logic [FRAME_BITS-1:0] wrFrame,
  input  logic                  wrValid,
  input  logic                  reqValid,
  input  logic [LOG_W-1:0]      reqAddr,
  output logic                  rspValid,
  output logic [PHYS_W-1:0]     rspAddr,
  output logic                  rspFault
);
  ctrlStrobes_t strobes;

  pt_translate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  pt_translate_datapath #(
    .PAGE_BITS   (PAGE_BITS),
    .OFFSET_BITS (OFFSET_BITS),
    .FRAME_BITS  (FRAME_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrIndex  (wrIndex),
    .wrFrame  (wrFrame),
    .wrValid  (wrValid),
    .reqAddr  (reqAddr),
    .rspAddr  (rspAddr),
    .rspFault (rspFault)
  );
endmodule

// File: rtl/page_translator_checker.sv
module page_translator_checker #(
  parameter int OFFSET_BITS = 2,
  parameter int PHYS_W      = 5
)(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic                   wrValid,
  input logic                   reqValid,
  input logic [OFFSET_BITS-1:0] reqOffset,
  input logic                   rspValid,
  input logic [PHYS_W-1:0]      rspAddr,
  input logic                   rspFault
);
  // Sticky: has any entry been made valid since reset?
  logic anyValidWrite;
  always_ff @(posedge clk) begin
    if (!rstN)                  anyValidWrite <= 1'b0;
    else if (wrEn && wrValid)   anyValidWrite <= 1'b1;
  end

  assert_reset_invalid_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !anyValidWrite) |-> rspFault);

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspFault || rspAddr[OFFSET_BITS-1:0] == $past(reqOffset)));

  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspAddr == '0));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspAddr) && $stable(rspFault)));
endmodule

bind page_translator page_translator_checker #(
  .OFFSET_BITS (OFFSET_BITS),
  .PHYS_W      (PHYS_W)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrValid   (wrValid),
  .reqValid  (reqValid),
  .reqOffset (reqAddr[OFFSET_BITS-1:0]),
  .rspValid  (rspValid),
  .rspAddr   (rspAddr),
  .rspFault  (rspFault)
);

// File: tb/page_translator_bench.sv
module page_translator_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn, wrValid, reqValid;
  logic [1:0] wrIndex;
  logic [2:0] wrFrame;
  logic [3:0] reqAddr;
  logic       rspValid, rspFault;
  logic [4:0] rspAddr;

  int checks = 0;
  int errors = 0;

  logic [2:0] modelFrame [4];
  logic       modelValid [4];

  always #4 clk = ~clk;   // 125 MHz

  page_translator u_page_translator (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIndex(wrIndex), .wrFrame(wrFrame),
    .wrValid(wrValid), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault)
  );

  function automatic logic [4:0] expAddr(input logic [3:0] a);
    int page = int'(a) / 4;
    int off  = int'(a) % 4;
    if (!modelValid[page]) return 5'd0;
    return 5'(int'(modelFrame[page]) * 4 + off);
  endfunction

  function automatic logic expFault(input logic [3:0] a);
    return !modelValid[int'(a) / 4];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; reqValid = 0; wrIndex = 0; wrFrame = 0; wrValid = 0; reqAddr = 0;
  endtask

  task automatic writeEntry(input int idx, input int fr, input logic v);
    @(negedge clk);
    idle();
    wrEn = 1; wrIndex = 2'(idx); wrFrame = 3'(fr); wrValid = v;
    @(negedge clk);
    idle();
    modelFrame[idx] = 3'(fr);
    modelValid[idx] = v;
  endtask

  // Request at a negedge; response is visible at the following negedge.
  task automatic request(input logic [3:0] a, input string req);
    logic [4:0] ea;
    logic ef;
    @(negedge clk);
    idle();
    reqValid = 1; reqAddr = a;
    ea = expAddr(a); ef = expFault(a);
    @(negedge clk);
    idle();
    check(rspValid == 1'b1, req, int'(rspValid), 1);
    check(rspAddr == ea, req, int'(rspAddr), int'(ea));
    check(rspFault == ef, req, int'(rspFault), int'(ef));
  endtask

  initial begin : watchdog
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [4:0] lastAddr;
    logic       lastFault;
    logic       pendReq;
    logic [4:0] pendAddr;
    logic       pendFault;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 4; i++) begin modelFrame[i] = 0; modelValid[i] = 0; end
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state of outputs
    check(rspValid == 0, "R1 rspValid", int'(rspValid), 0);
    check(rspAddr == 0, "R1 rspAddr", int'(rspAddr), 0);
    check(rspFault == 0, "R1 rspFault", int'(rspFault), 0);
    // R1/R4: every page faults before any write
    for (int p = 0; p < 4; p++) request(4'(p * 4 + 1), "R1 R4 fault after reset");

    // R9 / R3: worked example table
    writeEntry(0, 5, 1);
    writeEntry(1, 6, 1);
    writeEntry(3, 2, 1);
    request(4'd0, "R9 logical 0");
    check(rspAddr == 5'd20, "R9 addr 0->20", int'(rspAddr), 20);
    request(4'd3, "R9 logical 3");
    check(rspAddr == 5'd23, "R9 addr 3->23", int'(rspAddr), 23);
    request(4'd4, "R9 logical 4");
    check(rspAddr == 5'd24, "R9 addr 4->24", int'(rspAddr), 24);
    request(4'd13, "R9 logical 13");
    check(rspAddr == 5'd9, "R9 addr 13->9", int'(rspAddr), 9);
    check(rspFault == 0, "R5 valid no fault", int'(rspFault), 0);
    request(4'd7, "R3 offset 3 page 1");

    // R4: page 2 never written
    request(4'd10, "R4 unwritten page");
    check(rspAddr == 0 && rspFault == 1, "R4 zero on fault", int'(rspAddr), 0);

    // R8: outputs hold across idle cycles
    request(4'd13, "R8 setup");
    lastAddr = rspAddr; lastFault = rspFault;
    repeat (3) @(negedge clk);
    check(rspValid == 0, "R2 no strobe when idle", int'(rspValid), 0);
    check(rspAddr == lastAddr, "R8 addr hold", int'(rspAddr), int'(lastAddr));
    check(rspFault == lastFault, "R8 fault hold", int'(rspFault), int'(lastFault));

    // R6: invalidate page 1
    writeEntry(1, 6, 0);
    request(4'd5, "R6 invalidated page");
    check(rspFault == 1, "R6 invalidated faults", int'(rspFault), 1);
    writeEntry(1, 7, 1);
    request(4'd6, "R6 rewritten page");

    // R7: write and lookup of the same page in one cycle
    @(negedge clk);
    idle();
    reqValid = 1; reqAddr = 4'd1;
    wrEn = 1; wrIndex = 2'd0; wrFrame = 3'd3; wrValid = 1;
    @(negedge clk);
    idle();
    check(rspAddr == 5'd21, "R7 old entry used", int'(rspAddr), 21);
    modelFrame[0] = 3'd3;
    request(4'd1, "R7 new entry next");
    check(rspAddr == 5'd13, "R7 new entry value", int'(rspAddr), 13);

    // Random back-to-back traffic with writes: R2 R3 R4 R5 R6 R8
    pendReq = 0; pendAddr = 0; pendFault = 0;
    lastAddr = rspAddr; lastFault = rspFault;
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      if (pendReq) begin
        check(rspValid == 1, "R2 random strobe", int'(rspValid), 1);
        check(rspAddr == pendAddr, "R3 random addr", int'(rspAddr), int'(pendAddr));
        check(rspFault == pendFault, "R4 R5 random fault", int'(rspFault), int'(pendFault));
      end else begin
        check(rspValid == 0, "R2 random idle", int'(rspValid), 0);
        check(rspAddr == lastAddr && rspFault == lastFault, "R8 random hold",
              int'(rspAddr), int'(lastAddr));
      end
      lastAddr = rspAddr; lastFault = rspFault;
      idle();
      reqValid = ($urandom_range(0, 3) != 0);
      reqAddr  = 4'($urandom_range(0, 15));
      wrEn     = ($urandom_range(0, 3) == 0);
      wrIndex  = 2'($urandom_range(0, 3));
      wrFrame  = 3'($urandom_range(0, 7));
      wrValid  = ($urandom_range(0, 2) != 0);
      pendReq = reqValid;
      if (reqValid) begin pendAddr = expAddr(reqAddr); pendFault = expFault(reqAddr); end
      if (wrEn) begin modelFrame[wrIndex] = wrFrame; modelValid[wrIndex] = wrValid; end
    end
    @(negedge clk);
    if (pendReq) begin
      check(rspAddr == pendAddr, "R3 random last", int'(rspAddr), int'(pendAddr));
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule